// File: doc/BRIEF.md
# Time Slot to Channel Mapper

This block turns serial time slots into logical channel numbers for a multiport serial engine. A single shared descriptor table holds one entry per table address. Each entry carries a channel number and an active bit. Every serial port claims a contiguous window of that table through its own programmable pair of first and last addresses. Windows may differ in length. Several entries may name the same channel, so one channel can occupy many slots.

The serial engine presents one slot strobe at a time, tagged with the port number and a frame-start flag. The block keeps a slot pointer for each port. A strobe with the frame-start flag looks up the port's first address. Each later strobe looks up the next address, and the pointer returns to the first address after the last one. One cycle after the strobe, the block returns the port, the channel and whether the slot is active. Transmit and receive each use their own instance, so the two directions have separate tables and pointer pairs.

A port whose first address is above its last address is reported through a per-port configuration error flag and stays silent. Host writes to the table yield to slot strobes: a write that arrives together with a strobe is held and committed in the next cycle that has no strobe.

Top module: `tsm_mapper`

## Requirements
- R1: After synchronous reset, map_valid is 0, tbl_wr_ready is 1, every bit of cfg_err is 0, and every port is unarmed.
- R2: A slot strobe sampled at clock edge k that produces a lookup drives map_valid=1 and map_port equal to the strobe's port after edge k. Without a lookup, map_valid is 0 after edge k.
- R3: A strobe with slot_sync=1 reads the table entry at the port's first address and arms the port.
- R4: Each later strobe for an armed port reads the address one above the previous slot. After the slot at the last address, the next slot reads the first address again.
- R5: When the entry read has its active bit at 1, map_active is 1 and map_chan is the stored channel. When the active bit is 0, map_active is 0 and map_chan is 0.
- R6: A strobe without slot_sync for a port that is unarmed gives map_valid=0. A port becomes unarmed after reset and after any write to its pointer pair.
- R7: A pointer write with first above last sets cfg_err for that port from the next cycle. All strobes for that port then give map_valid=0. A later write with first not above last clears the flag.
- R8: Each port keeps its own slot pointer, so interleaved strobes from different ports do not disturb one another's sequence.
- R9: A table write accepted in a cycle with a slot strobe does not affect that cycle's lookup. tbl_wr_ready is then 0 for one cycle, and the write is committed in the next cycle without a strobe.
- R10: A window whose first and last addresses are equal reads that same entry on every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table entry write request, taken when tbl_wr_ready is 1 |
| tbl_wr_addr | input | ADDR_W | Table address to write |
| tbl_wr_chan | input | 8 | Channel number for the entry |
| tbl_wr_act | input | 1 | Active bit for the entry |
| tbl_wr_ready | output | 1 | 0 while a deferred write is waiting |
| ptr_wr_en | input | 1 | Pointer pair write strobe |
| ptr_wr_port | input | PORT_W | Port whose pointer pair is written |
| ptr_wr_first | input | ADDR_W | First table address of the window |
| ptr_wr_last | input | ADDR_W | Last table address of the window |
| slot_req | input | 1 | Slot strobe |
| slot_port | input | PORT_W | Port owning the slot |
| slot_sync | input | 1 | Slot is the first of a frame |
| map_valid | output | 1 | Lookup result present |
| map_port | output | PORT_W | Port of the result |
| map_chan | output | 8 | Channel number, 0 when inactive |
| map_active | output | 1 | Slot is active |
| cfg_err | output | N_PORTS | Per-port pointer order error |

## Verification
On every cycle, the assertions check four properties. An armed port's slot pointer stays inside its window. A pointer write with reversed order raises that port's error flag. Every result is traced back to a strobe on the previous cycle with the same port. A deferred write is held while strobes continue and is drained as soon as a strobe-free cycle arrives. The actual addresses visited, the wrap back to the first entry, the channel values and the interplay of interleaved ports depend on table contents. The bench scenarios cover these, together with the error recovery and the old-value lookup during a write collision.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  parameter int TSM_CH_W = 8;

  typedef struct packed {
    logic                act;
    logic [TSM_CH_W-1:0] chan;
  } tsm_entry_t;
endpackage

// File: rtl/tsm_table.sv
module tsm_table
  import tsm_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  tsm_entry_t        wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output tsm_entry_t        rd_data
);
  tsm_entry_t        mem [DEPTH];
  tsm_entry_t        rd_q;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  tsm_entry_t        pend_data;

  logic              wr_acc;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  tsm_entry_t        c_data;

  assign wr_acc = wr_req && !pend_v;
  assign commit = !rd_en && (pend_v || wr_acc);
  assign c_addr = pend_v ? pend_addr : wr_addr;
  assign c_data = pend_v ? pend_data : wr_data;

  // Single-port style array: writes only between strobes, read-first.
  always_ff @(posedge clk) begin
    if (commit) mem[c_addr] <= c_data;
    if (rd_en)  rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (pend_v) begin
      if (!rd_en) pend_v <= 1'b0;
    end else if (wr_acc && rd_en) begin
      pend_v    <= 1'b1;
      pend_addr <= wr_addr;
      pend_data <= wr_data;
    end
  end

  assign wr_ready = !pend_v;
  assign rd_data  = rd_q;

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ready && rd_en) |=> !wr_ready);
  // R9
  pend_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !rd_en) |=> wr_ready);
endmodule

// File: rtl/tsm_port_ctrl.sv
module tsm_port_ctrl #(
  parameter int N_PORTS = 32,
  parameter int ADDR_W  = 12,
  parameter int PORT_W  = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_we,
  input  logic [PORT_W-1:0]  ptr_port,
  input  logic [ADDR_W-1:0]  ptr_first,
  input  logic [ADDR_W-1:0]  ptr_last,
  input  logic               req_valid,
  input  logic [PORT_W-1:0]  req_port,
  input  logic               req_sync,
  output logic               lk_valid,
  output logic [ADDR_W-1:0]  lk_addr,
  output logic [N_PORTS-1:0] cfg_err
);
  logic [ADDR_W-1:0] first_a [N_PORTS];
  logic [ADDR_W-1:0] last_a  [N_PORTS];
  logic [ADDR_W-1:0] cur_a   [N_PORTS];
  logic [N_PORTS-1:0] armed_v;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    base     = req_sync ? first_a[req_port] : cur_a[req_port];
    lk_valid = req_valid && !cfg_err[req_port] && (req_sync || armed_v[req_port]);
    nxt      = (base == last_a[req_port]) ? first_a[req_port] : base + 1'b1;
  end
  assign lk_addr = base;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic [ADDR_W-1:0] first_r, last_r, cur_r;
    logic              armed_r, err_r;
    logic              hit, sel;

    assign hit = lk_valid && (req_port == PORT_W'(g));
    assign sel = ptr_we && (ptr_port == PORT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        first_r <= '0;
        last_r  <= '0;
        cur_r   <= '0;
        armed_r <= 1'b0;
        err_r   <= 1'b0;
      end else begin
        if (hit) begin
          cur_r   <= nxt;
          armed_r <= 1'b1;
        end
        if (sel) begin
          first_r <= ptr_first;
          last_r  <= ptr_last;
          err_r   <= ptr_first > ptr_last;
          armed_r <= 1'b0;
        end
      end
    end

    assign first_a[g]  = first_r;
    assign last_a[g]   = last_r;
    assign cur_a[g]    = cur_r;
    assign armed_v[g]  = armed_r;
    assign cfg_err[g]  = err_r;

    // R4
    win_bound_chk: assert property (@(posedge clk) disable iff (rst)
      armed_r |-> (cur_r >= first_r && cur_r <= last_r));
  end

  // R7
  order_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ptr_we) && !$past(rst) && ($past(ptr_first) > $past(ptr_last)))
      |-> cfg_err[$past(ptr_port)]);
endmodule

// File: rtl/tsm_mapper.sv
module tsm_mapper
  import tsm_pkg::*;
#(
  parameter int N_PORTS = 32,
  parameter int DEPTH   = 4096,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int PORT_W  = $clog2(N_PORTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_wr_en,
  input  logic [ADDR_W-1:0]   tbl_wr_addr,
  input  logic [TSM_CH_W-1:0] tbl_wr_chan,
  input  logic                tbl_wr_act,
  output logic                tbl_wr_ready,
  input  logic                ptr_wr_en,
  input  logic [PORT_W-1:0]   ptr_wr_port,
  input  logic [ADDR_W-1:0]   ptr_wr_first,
  input  logic [ADDR_W-1:0]   ptr_wr_last,
  input  logic                slot_req,
  input  logic [PORT_W-1:0]   slot_port,
  input  logic                slot_sync,
  output logic                map_valid,
  output logic [PORT_W-1:0]   map_port,
  output logic [TSM_CH_W-1:0] map_chan,
  output logic                map_active,
  output logic [N_PORTS-1:0]  cfg_err
);
  logic              lk_valid;
  logic [ADDR_W-1:0] lk_addr;
  tsm_entry_t        wr_ent;
  tsm_entry_t        rd_ent;
  logic              v_q;
  logic [PORT_W-1:0] port_q;

  assign wr_ent.act  = tbl_wr_act;
  assign wr_ent.chan = tbl_wr_chan;

  tsm_port_ctrl #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ptr_we    (ptr_wr_en),
    .ptr_port  (ptr_wr_port),
    .ptr_first (ptr_wr_first),
    .ptr_last  (ptr_wr_last),
    .req_valid (slot_req),
    .req_port  (slot_port),
    .req_sync  (slot_sync),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .cfg_err   (cfg_err)
  );

  tsm_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (tbl_wr_en),
    .wr_addr  (tbl_wr_addr),
    .wr_data  (wr_ent),
    .wr_ready (tbl_wr_ready),
    .rd_en    (slot_req),
    .rd_addr  (lk_addr),
    .rd_data  (rd_ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      port_q <= '0;
    end else begin
      v_q    <= lk_valid;
      port_q <= slot_port;
    end
  end

  assign map_valid  = v_q;
  assign map_port   = port_q;
  assign map_active = v_q && rd_ent.act;
  assign map_chan   = map_active ? rd_ent.chan : '0;

  // R2
  result_src_chk: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> (!$past(rst) && $past(slot_req) && map_port == $past(slot_port)));
endmodule

// File: tb/tsm_mapper_tb.sv
module tsm_mapper_tb;
  localparam int NP = 32;
  localparam int AW = 12;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tbl_wr_en = 1'b0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [7:0]    tbl_wr_chan = '0;
  logic          tbl_wr_act = 1'b0;
  logic          tbl_wr_ready;
  logic          ptr_wr_en = 1'b0;
  logic [PW-1:0] ptr_wr_port = '0;
  logic [AW-1:0] ptr_wr_first = '0;
  logic [AW-1:0] ptr_wr_last = '0;
  logic          slot_req = 1'b0;
  logic [PW-1:0] slot_port = '0;
  logic          slot_sync = 1'b0;
  logic          map_valid;
  logic [PW-1:0] map_port;
  logic [7:0]    map_chan;
  logic          map_active;
  logic [NP-1:0] cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tsm_mapper u_dut (
    .clk(clk), .rst(rst),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_chan(tbl_wr_chan),
    .tbl_wr_act(tbl_wr_act), .tbl_wr_ready(tbl_wr_ready),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_port(ptr_wr_port), .ptr_wr_first(ptr_wr_first),
    .ptr_wr_last(ptr_wr_last),
    .slot_req(slot_req), .slot_port(slot_port), .slot_sync(slot_sync),
    .map_valid(map_valid), .map_port(map_port), .map_chan(map_chan),
    .map_active(map_active), .cfg_err(cfg_err)
  );

  // Bench-chosen table contents.
  function automatic logic [7:0] ch_of(int a);
    return 8'((a * 7 + 3) % 256);
  endfunction
  function automatic logic act_of(int a);
    return (a % 4) != 3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr_tbl(int a, logic [7:0] c, logic en);
    tbl_wr_en = 1'b1; tbl_wr_addr = AW'(a); tbl_wr_chan = c; tbl_wr_act = en;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wr_ptr(int p, int f, int l);
    ptr_wr_en = 1'b1; ptr_wr_port = PW'(p); ptr_wr_first = AW'(f); ptr_wr_last = AW'(l);
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic slot(int p, logic s);
    slot_req = 1'b1; slot_port = PW'(p); slot_sync = s;
    @(negedge clk);
    slot_req = 1'b0; slot_sync = 1'b0;
  endtask

  // {port[18:14], sync[13], exp_valid[12], exp_addr[11:0]}
  localparam logic [18:0] VEC [14] = '{
    {5'd0,  1'b0, 1'b0, 12'd0},    // R6 unarmed
    {5'd0,  1'b1, 1'b1, 12'd10},   // R3
    {5'd0,  1'b0, 1'b1, 12'd11},   // R4, R5 inactive entry
    {5'd3,  1'b1, 1'b1, 12'd100},  // R3, R8
    {5'd0,  1'b0, 1'b1, 12'd12},   // R8
    {5'd3,  1'b0, 1'b1, 12'd101},  // R4
    {5'd0,  1'b0, 1'b1, 12'd13},   // R4
    {5'd0,  1'b0, 1'b1, 12'd10},   // R4 wrap
    {5'd3,  1'b0, 1'b1, 12'd102},  // R4
    {5'd3,  1'b0, 1'b1, 12'd100},  // R4 wrap
    {5'd31, 1'b1, 1'b1, 12'd4000}, // R10
    {5'd31, 1'b0, 1'b1, 12'd4000}, // R10
    {5'd0,  1'b1, 1'b1, 12'd10},   // R3 resync
    {5'd0,  1'b0, 1'b1, 12'd11}    // R4
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 map_valid", map_valid, 0);
    chk("R1 tbl_wr_ready", tbl_wr_ready, 1);
    chk("R1 cfg_err", int'(cfg_err), 0);

    foreach (VEC[i]) wr_tbl(int'(VEC[i][11:0]), ch_of(int'(VEC[i][11:0])), act_of(int'(VEC[i][11:0])));
    wr_tbl(199, ch_of(199), act_of(199));
    wr_ptr(0, 10, 13);
    wr_ptr(3, 100, 102);
    wr_ptr(31, 4000, 4000);

    for (int i = 0; i < 14; i++) begin
      logic [18:0] v;
      int a;
      v = VEC[i];
      a = int'(v[11:0]);
      slot(int'(v[18:14]), v[13]);
      chk("R2/R6 map_valid", map_valid, int'(v[12]));
      if (v[12]) begin
        chk("R2/R8 map_port", map_port, int'(v[18:14]));
        chk("R5 map_active", map_active, int'(act_of(a)));
        chk("R3/R4/R10 map_chan", map_chan, act_of(a) ? int'(ch_of(a)) : 0);
      end
    end

    // R6: pointer rewrite disarms port 0
    wr_ptr(0, 10, 13);
    slot(0, 1'b0);
    chk("R6 map_valid after ptr write", map_valid, 0);

    // R7: reversed window
    wr_ptr(5, 200, 199);
    chk("R7 cfg_err set", int'(cfg_err[5]), 1);
    slot(5, 1'b1);
    chk("R7 silent port", map_valid, 0);
    wr_ptr(5, 199, 200);
    chk("R7 cfg_err cleared", int'(cfg_err[5]), 0);
    slot(5, 1'b1);
    chk("R7 recovered valid", map_valid, 1);
    chk("R7 recovered chan", map_chan, act_of(199) ? int'(ch_of(199)) : 0);

    // R9: write collides with a strobe
    wr_tbl(50, 8'd1, 1'b1);
    wr_ptr(7, 50, 50);
    slot(7, 1'b1);
    chk("R9 setup chan", map_chan, 1);
    tbl_wr_en = 1'b1; tbl_wr_addr = 12'd50; tbl_wr_chan = 8'd2; tbl_wr_act = 1'b1;
    slot_req = 1'b1; slot_port = 5'd7; slot_sync = 1'b0;
    @(negedge clk);
    tbl_wr_en = 1'b0; slot_req = 1'b0;
    chk("R9 old value read", map_chan, 1);
    chk("R9 ready low", tbl_wr_ready, 0);
    @(negedge clk);
    chk("R9 ready restored", tbl_wr_ready, 1);
    slot(7, 1'b0);
    chk("R9 committed value", map_chan, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule